// File: doc/BRIEF.md
# Delimited Frame Extractor FIFO

This block is a byte receive buffer placed between a serial receiver and a frame handler. The receiver pushes one byte per cycle whenever `in_valid` is high, and the write side never stalls. Bytes go into a 64-entry circular store. When the store is full, each new byte replaces the oldest stored byte.

On the read side, a scanner walks the stored bytes. It advances only in cycles where `scan_tick` is high, so scanning does not have to keep pace with byte arrival. The scanner looks for a start delimiter and an end delimiter, and both byte values are run-time inputs. The block releases only whole frames, from start delimiter to end delimiter. It streams the payload under a valid/ready handshake, with first and last markers on the payload bytes. The delimiters themselves are never passed on.

The scanner drops a partial frame when a fresh start delimiter appears. It also drops frames that grow too long and frames damaged by an overwrite. Each of the last two cases raises a one-cycle pulse.

Top module: `frame_extract_fifo`

## Requirements
- R1: After reset, `out_valid`, `len_err` and `ovf_event` are low and the store is empty.
- R2: Bytes that arrive while no start delimiter is being tracked are discarded, including bytes equal to `eof_byte`. The delimiter values are taken from `sof_byte` and `eof_byte`.
- R3: The payload of a frame is delivered in arrival order, with `out_first` on its first byte and `out_last` on its last byte. The frame consists of a start delimiter, 1 to 60 bytes that equal neither delimiter, and then an end delimiter. Neither delimiter is output.
- R4: A start delimiter seen while a frame is being collected discards the bytes collected so far. Collection restarts from that newer delimiter.
- R5: A start delimiter followed directly by an end delimiter produces no output.
- R6: A frame whose payload reaches 61 bytes without an end delimiter is dropped, and `len_err` is high for exactly one cycle. A 60-byte payload is accepted.
- R7: Writes are never refused. With 64 bytes stored, a new byte replaces the oldest byte. If the replaced byte belongs to the frame being collected or emitted, that frame is abandoned, no further byte of it is issued, and `ovf_event` pulses for one cycle. An overwrite while no frame is tracked gives no pulse.
- R8: The scanner consumes or examines stored bytes only in cycles with `scan_tick` high. While `scan_tick` is low, a complete stored frame produces no output.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the receiver |
| in_byte | input | 8 | Received byte |
| sof_byte | input | 8 | Start delimiter value |
| eof_byte | input | 8 | End delimiter value |
| scan_tick | input | 1 | Enables one scanner step |
| out_valid | output | 1 | Payload byte available |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | First payload byte of a frame |
| out_last | output | 1 | Last payload byte of a frame |
| out_ready | input | 1 | Downstream accepts the byte |
| len_err | output | 1 | One-cycle pulse: over-length frame dropped |
| ovf_event | output | 1 | One-cycle pulse: tracked frame lost to an overwrite |

## Verification
The assertions assume three things about the inputs:
- `sof_byte` and `eof_byte` hold steady while a frame is in flight.
- The two delimiter values differ.
- The downstream side does not depend on a byte being withdrawn.

The stimulus changes delimiter values only while the block is idle, after enough quiet cycles for every frame to drain. Payload bytes are generated below 0x80, and the delimiters are placed at 0xC0 and above. Overflow is provoked deliberately, either by holding `scan_tick` low or by holding `out_ready` low, so that the buffer fills at a known byte count.

// File: rtl/fx_pkg.sv
package fx_pkg;
    typedef enum logic [1:0] {
        SC_HUNT    = 2'd0,
        SC_COLLECT = 2'd1,
        SC_EMIT    = 2'd2
    } scan_st_t;
endpackage

// File: rtl/fx_byte_ring.sv
module fx_byte_ring #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_byte,
    output logic [PW-1:0] wr_ptr,
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic [DW-1:0] data_a,
    output logic [DW-1:0] data_b
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_d, wr_q;

    always_comb begin
        wr_d = wr_q;
        if (wr_en) wr_d = wr_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_q[AW-1:0]] <= wr_byte;
    end

    assign wr_ptr = wr_q;
    assign data_a = mem[addr_a];
    assign data_b = mem[addr_b];
endmodule

// File: rtl/fx_scanner.sv
module fx_scanner
    import fx_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int DW      = 8,
    parameter int MAX_LEN = 60,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] sof_byte,
    input  logic [DW-1:0] eof_byte,
    input  logic          scan_tick,
    input  logic          slot_free,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] sc_addr,
    input  logic [DW-1:0] rd_byte,
    input  logic [DW-1:0] sc_byte,
    output logic          load,
    output logic          ld_first,
    output logic          ld_last,
    output logic          len_err,
    output logic          ovf
);
    localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
    localparam logic [PW-1:0] MAX_P  = PW'(MAX_LEN);

    typedef struct packed {
        scan_st_t      st;
        logic [PW-1:0] rd;
        logic [PW-1:0] sc;
        logic [PW-1:0] rem;
        logic          first;
        logic          len_err;
        logic          ovf;
    } sc_state_t;

    sc_state_t     s_d, s_q;
    logic [PW-1:0] rd_scan, occ_q, occ_n, flen;

    always_comb begin
        s_d         = s_q;
        s_d.len_err = 1'b0;
        s_d.ovf     = 1'b0;
        rd_scan     = s_q.rd;
        load        = 1'b0;
        ld_first    = 1'b0;
        ld_last     = 1'b0;
        occ_q       = wr_ptr - s_q.rd;
        flen        = s_q.sc - s_q.rd - PW'(1);
        unique case (s_q.st)
            SC_HUNT: begin
                if (scan_tick && occ_q != '0) begin
                    if (rd_byte == sof_byte) begin
                        s_d.st = SC_COLLECT;
                        s_d.sc = s_q.rd + PW'(1);
                    end else begin
                        rd_scan = s_q.rd + PW'(1);
                    end
                end
            end
            SC_COLLECT: begin
                if (scan_tick && s_q.sc != wr_ptr) begin
                    if (sc_byte == sof_byte) begin
                        rd_scan = s_q.sc;
                        s_d.sc  = s_q.sc + PW'(1);
                    end else if (sc_byte == eof_byte) begin
                        if (flen == '0) begin
                            rd_scan = s_q.sc + PW'(1);
                            s_d.st  = SC_HUNT;
                        end else begin
                            rd_scan   = s_q.rd + PW'(1);
                            s_d.rem   = flen;
                            s_d.first = 1'b1;
                            s_d.st    = SC_EMIT;
                        end
                    end else if (flen == MAX_P) begin
                        rd_scan     = s_q.sc;
                        s_d.st      = SC_HUNT;
                        s_d.len_err = 1'b1;
                    end else begin
                        s_d.sc = s_q.sc + PW'(1);
                    end
                end
            end
            SC_EMIT: begin
                if (slot_free) begin
                    load      = 1'b1;
                    ld_first  = s_q.first;
                    ld_last   = (s_q.rem == PW'(1));
                    s_d.first = 1'b0;
                    s_d.rem   = s_q.rem - PW'(1);
                    if (s_q.rem == PW'(1)) begin
                        rd_scan = s_q.rd + PW'(2);
                        s_d.st  = SC_HUNT;
                    end else begin
                        rd_scan = s_q.rd + PW'(1);
                    end
                end
            end
            default: s_d.st = SC_HUNT;
        endcase
        occ_n = wr_ptr - rd_scan;
        if (wr_en && occ_n == FULL_P) begin
            s_d.rd = rd_scan + PW'(1);
            if (s_d.st != SC_HUNT) begin
                s_d.st  = SC_HUNT;
                s_d.ovf = 1'b1;
            end
        end else begin
            s_d.rd = rd_scan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st      <= SC_HUNT;
            s_q.rd      <= '0;
            s_q.sc      <= '0;
            s_q.rem     <= '0;
            s_q.first   <= 1'b0;
            s_q.len_err <= 1'b0;
            s_q.ovf     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_addr = s_q.rd[AW-1:0];
    assign sc_addr = s_q.sc[AW-1:0];
    assign len_err = s_q.len_err;
    assign ovf     = s_q.ovf;

    logic [PW-1:0] flen_q;
    assign flen_q = s_q.sc - s_q.rd - PW'(1);

    // R7: the stored span never exceeds the store depth
    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr - s_q.rd) <= FULL_P);
    // R6: collected payload never passes the length limit
    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SC_COLLECT) |-> (flen_q <= MAX_P));
    // R6: length error is a single-cycle pulse
    a_r6_len_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> !len_err);
    // R7: overflow abort is a single-cycle pulse
    a_r7_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);
    // R3: emission always has payload left to send
    a_r3_emit_rem: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SC_EMIT) |-> (s_q.rem != '0));
    // R8: without a tick and without emission, no stored byte is consumed
    a_r8_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_tick && s_q.st != SC_EMIT && !wr_en) |=> (s_q.rd == $past(s_q.rd)));
endmodule

// File: rtl/fx_out_stage.sv
module fx_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_first,
    input  logic          ld_last,
    output logic          slot_free,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] data;
        logic          first;
        logic          last;
    } ob_t;

    ob_t o_d, o_q;

    always_comb begin
        o_d = o_q;
        if (load) begin
            o_d.v     = 1'b1;
            o_d.data  = ld_data;
            o_d.first = ld_first;
            o_d.last  = ld_last;
        end else if (out_ready) begin
            o_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign slot_free = !o_q.v || out_ready;
    assign out_valid = o_q.v;
    assign out_data  = o_q.data;
    assign out_first = o_q.first;
    assign out_last  = o_q.last;

    // R9: a held byte keeps its value and markers
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_first) && $stable(out_last)));
    // R9: the scanner never loads into an occupied, stalled slot
    a_r9_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !load);
endmodule

// File: rtl/frame_extract_fifo.sv
module frame_extract_fifo #(
    parameter int DEPTH   = 64,
    parameter int DW      = 8,
    parameter int MAX_LEN = 60,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    input  logic [DW-1:0] sof_byte,
    input  logic [DW-1:0] eof_byte,
    input  logic          scan_tick,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_first,
    output logic          out_last,
    input  logic          out_ready,
    output logic          len_err,
    output logic          ovf_event
);
    logic [PW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr, sc_addr;
    logic [DW-1:0] rd_byte, sc_byte;
    logic          slot_free, load, ld_first, ld_last;

    fx_byte_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_byte (in_byte),
        .wr_ptr  (wr_ptr),
        .addr_a  (rd_addr),
        .addr_b  (sc_addr),
        .data_a  (rd_byte),
        .data_b  (sc_byte)
    );

    fx_scanner #(.DEPTH(DEPTH), .DW(DW), .MAX_LEN(MAX_LEN)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_ptr    (wr_ptr),
        .sof_byte  (sof_byte),
        .eof_byte  (eof_byte),
        .scan_tick (scan_tick),
        .slot_free (slot_free),
        .rd_addr   (rd_addr),
        .sc_addr   (sc_addr),
        .rd_byte   (rd_byte),
        .sc_byte   (sc_byte),
        .load      (load),
        .ld_first  (ld_first),
        .ld_last   (ld_last),
        .len_err   (len_err),
        .ovf       (ovf_event)
    );

    fx_out_stage #(.DW(DW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_data   (rd_byte),
        .ld_first  (ld_first),
        .ld_last   (ld_last),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_first (out_first),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    // R1: no pulse and no output in the cycle after reset release
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !len_err && !ovf_event));
endmodule

// File: tb/frame_extract_fifo_tb.sv
module frame_extract_fifo_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] sof_byte = 8'hC0;
    logic [7:0] eof_byte = 8'hD0;
    logic       scan_tick = 1'b1;
    logic       out_ready = 1'b1;
    logic       out_valid, out_first, out_last, len_err, ovf_event;
    logic [7:0] out_data;

    frame_extract_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .sof_byte(sof_byte), .eof_byte(eof_byte), .scan_tick(scan_tick),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_ready(out_ready), .len_err(len_err),
        .ovf_event(ovf_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0;
    int rdy_mode = 0, cyc = 0;
    int frames = 0, bytes_total = 0, len_cnt = 0, ovf_cnt = 0, hold_err = 0;
    int rx_n = 0, got_n = 0, exp_n = 0;
    logic [7:0] rx [0:127];
    logic [7:0] got [0:127];
    logic [7:0] exp_b [0:127];
    logic       hold_pend = 1'b0;
    logic [9:0] hold_val;

    initial forever begin
        @(posedge clk); #1;
        if (rdy_mode == 0)      out_ready = 1'b1;
        else if (rdy_mode == 1) out_ready = (cyc % 3) != 0;
        else                    out_ready = 1'b0;
        cyc++;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && (!out_valid || {out_data, out_first, out_last} != hold_val))
                hold_err++;
            hold_pend = out_valid && !out_ready;
            hold_val  = {out_data, out_first, out_last};
            if (len_err)   len_cnt++;
            if (ovf_event) ovf_cnt++;
            if (out_valid && out_ready) begin
                bytes_total++;
                if (out_first) rx_n = 0;
                if (rx_n < 128) rx[rx_n] = out_data;
                rx_n++;
                if (out_last) begin
                    got_n = rx_n;
                    for (int i = 0; i < 128; i++) got[i] = rx[i];
                    frames++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] pay(input int i, input int base);
        return 8'((i * 13 + base) & 8'h7F);
    endfunction

    task automatic send_frame(input int n, input int base);
        wr(sof_byte);
        for (int i = 0; i < n; i++) begin
            exp_b[i] = pay(i, base);
            wr(exp_b[i]);
        end
        exp_n = n;
        wr(eof_byte);
    endtask

    task automatic chk_frame(input string tag);
        int bad;
        bad = 0;
        chk(got_n == exp_n, {tag, " length"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < 128; i++)
            if (got[i] != exp_b[i]) bad++;
        chk(bad == 0, {tag, " content mismatches"}, bad, 0);
    endtask

    initial begin
        int f0, l0, o0, b0;
        #1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(!len_err && !ovf_event, "R1 pulses after reset", {len_err, ovf_event}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(out_valid == 1'b0, "R1 empty store gives no output", out_valid, 0);

        // R2 R3 R6: sweep of payload lengths 1..60, junk prefix holding the end value
        for (int len = 1; len <= 60; len++) begin
            sof_byte = 8'hC0 + 8'(len % 4);
            eof_byte = 8'hD0 + 8'(len % 4);
            rdy_mode = len % 2;
            f0 = frames;
            wr(eof_byte); wr(8'h11); wr(8'h22);
            send_frame(len, len);
            idle(200);
            chk(frames == f0 + 1, "R2 R3 one frame per sweep step", frames - f0, 1);
            chk_frame("R3 sweep");
        end
        chk(len_cnt == 0, "R6 sixty-byte payload accepted without error", len_cnt, 0);
        rdy_mode = 0;
        sof_byte = 8'hC7; eof_byte = 8'hD7;

        // R5: empty frame
        f0 = frames; b0 = bytes_total;
        wr(sof_byte); wr(eof_byte);
        idle(50);
        chk(bytes_total == b0, "R5 empty frame emits nothing", bytes_total - b0, 0);

        // R4: restart on a repeated start delimiter
        f0 = frames;
        wr(sof_byte); wr(8'h41); wr(8'h42);
        send_frame(3, 5);
        idle(60);
        chk(frames == f0 + 1, "R4 one frame after restart", frames - f0, 1);
        chk_frame("R4 restarted frame");

        // R6: over-length payload dropped
        f0 = frames; l0 = len_cnt; b0 = bytes_total;
        wr(sof_byte);
        for (int i = 0; i < 61; i++) wr(pay(i, 9));
        wr(eof_byte);
        idle(60);
        chk(len_cnt == l0 + 1, "R6 length error pulses once", len_cnt - l0, 1);
        chk(bytes_total == b0, "R6 over-length frame not emitted", bytes_total - b0, 0);

        // R8: no scanning without tick
        scan_tick = 1'b0;
        f0 = frames;
        send_frame(2, 20);
        idle(60);
        chk(frames == f0 && !out_valid, "R8 frame held without tick", frames - f0, 0);
        scan_tick = 1'b1;
        idle(40);
        chk(frames == f0 + 1, "R8 frame released with tick", frames - f0, 1);
        chk_frame("R8 frame");

        // R7: overwrite of oldest bytes while hunting
        scan_tick = 1'b0;
        f0 = frames; o0 = ovf_cnt;
        wr(sof_byte); wr(8'h31); wr(8'h32); wr(eof_byte);
        for (int i = 0; i < 56; i++) wr(8'h05);
        send_frame(10, 33);
        idle(5);
        chk(ovf_cnt == o0, "R7 no pulse when overwrite hits untracked bytes", ovf_cnt - o0, 0);
        scan_tick = 1'b1;
        idle(120);
        chk(frames == f0 + 1, "R7 oldest frame overwritten, newest kept", frames - f0, 1);
        chk_frame("R7 surviving frame");

        // R7: overwrite during emission abandons the frame
        rdy_mode = 2;
        idle(2);
        f0 = frames; o0 = ovf_cnt; b0 = bytes_total;
        send_frame(5, 44);
        for (int i = 0; i < 64; i++) wr(8'h05);
        idle(5);
        chk(ovf_cnt == o0 + 1, "R7 overflow pulse on tracked frame", ovf_cnt - o0, 1);
        chk(out_valid && out_first, "R9 held byte kept while stalled", out_valid, 1);
        rdy_mode = 0;
        idle(120);
        chk(bytes_total == b0 + 1, "R7 no byte after abort", bytes_total - b0, 1);
        chk(frames == f0, "R7 abandoned frame never completes", frames - f0, 0);
        f0 = frames;
        send_frame(4, 50);
        idle(40);
        chk(frames == f0 + 1, "R7 recovery frame delivered", frames - f0, 1);
        chk_frame("R7 recovery frame");

        // R9: hold rule across the whole run
        chk(hold_err == 0, "R9 stable output while stalled", hold_err, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule